// File: doc/BRIEF.md
# Boundary Scan Cell Clock Generator

This block sits beside a JTAG TAP controller. It converts the controller's state indications (capture, shift, update) and the boundary-scan instruction selects into the strobes that a chain of latch-based boundary cells needs. The chain's shift register is built from master/slave latch pairs, so the block provides two separate non-overlapping shift enables instead of one flop clock enable. It also provides a capture clock, an update latch enable, a latch-select for the cell output mux and an active-low shift-mode level.

Every strobe rests at a level that keeps the pass gates inside the cells from fighting each other. Both shift enables rest low, the capture clock rests high and the update enable rests low. State indications are sampled on the falling TCK edge. The strobes are then formed from those sampled levels and the live TCK phase. A separate gated clock is provided for scan logic that only needs to run during capture or shift. Its enable is sampled on the falling edge, so the gated clock carries no glitches.

The instruction selects form a 3-bit vector: bit 0 is external test, bit 1 is sample, bit 2 is internal test. The TAP controller is expected to update its state outputs after the rising TCK edge.

Top module: `bscan_clkgen`

## Requirements
- R1: The master enable `shf_a` (active high) and the slave enable `shf_b` (active low) never overlap. `shf_a` is never 1 while `shf_b` is 0, in either TCK phase.
- R2: Both `shf_a` and `shf_b` are 0 whenever the last falling TCK edge did not see shift together with a boundary instruction. Both are also 0 in every TCK-low phase.
- R3: When the last falling edge saw `st_shift`=1 and any bit of `ins_sel` set, `shf_a` and `shf_b` are both 1 in the following TCK-high phase. `shf_b` is 0 (slave open) in the low phase.
- R4: `cap_clk` is 0 during the TCK-low phase that starts at a falling edge which saw `st_capture`=1 and a boundary instruction. Its rising edge therefore falls on the rising TCK edge. At all other times `cap_clk` is 1.
- R5: `upd_en` is 1 only during the TCK-low phase that starts at a falling edge which saw `st_update`=1 and a boundary instruction. At all other times it is 0, including every TCK-high phase.
- R6: `sel_ff` is updated at each falling edge. It becomes 1 when `ins_sel` bit 0 (external test) or bit 2 (internal test) is set. It becomes 0 when only bit 1 (sample) is set or when no bit is set.
- R7: `mode_n` is 0 from a falling edge that saw shift with a boundary instruction until the next falling edge. At all other times it is 1.
- R8: `gclk` is 0 in every TCK-low phase. In a TCK-high phase it is 1 exactly when the last falling edge saw `st_capture` or `st_shift`, whatever the instruction.
- R9: While `trst_n` is 0, every output is at its idle level at once: `shf_a`=0, `shf_b`=0, `cap_clk`=1, `upd_en`=0, `sel_ff`=0, `mode_n`=1, `gclk`=0. After release, the outputs stay idle until a falling edge samples new state.
- R10: With `ins_sel`=0, the capture, shift and update states leave `shf_a`, `shf_b`, `cap_clk`, `upd_en` and `mode_n` at their idle levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Active-low test reset |
| st_capture | input | 1 | TAP is in a capture state |
| st_shift | input | 1 | TAP is in a shift state |
| st_update | input | 1 | TAP is in an update state |
| ins_sel | input | 3 | Instruction selects: bit0 external test, bit1 sample, bit2 internal test |
| shf_a | output | 1 | Master shift latch enable, active high |
| shf_b | output | 1 | Slave shift latch enable, active low, rests low |
| cap_clk | output | 1 | Capture clock, rising-edge active, rests high |
| upd_en | output | 1 | Update latch enable, active high |
| sel_ff | output | 1 | Select update latch onto cell path |
| mode_n | output | 1 | Boundary shift mode, active low |
| gclk | output | 1 | Gated capture/shift clock |

## Verification
The bench compares every output in both TCK phases of every cycle, so a strobe that opens half a period early or late shows up as a mismatch. If the non-overlap rule is broken, the master and slave latches of a cell would be open together. A design that skipped the falling-edge register would let the gated clock and the capture clock follow input changes in mid-phase. Cases where only the sample instruction is selected, or no instruction at all, catch a latch select that wrongly drives the cell output. They also catch shift strobes that run without a boundary instruction. A reset asserted in the middle of a shift high phase confirms that the idle levels appear without waiting for an edge.

// File: rtl/bsc_pkg.sv
`timescale 1ns/1ps
// Shared types for the boundary scan clock generator.
package bsc_pkg;

    // Levels sampled on the falling TCK edge; each drives one strobe family.
    typedef struct packed {
        logic cap;   // capture with a boundary instruction
        logic sft;   // shift with a boundary instruction
        logic upd;   // update with a boundary instruction
        logic en;    // capture or shift, any instruction
        logic sel;   // latch-select instruction active
    } bsc_phase_t;

    // Idle value of the sampled state.
    localparam bsc_phase_t BSC_PHASE_IDLE = '0;

endpackage

// File: rtl/bsc_phase_reg.sv
`timescale 1ns/1ps
// Falling-edge state register.
// Samples the TAP state indications and instruction decode on the falling
// TCK edge. The outputs are then stable for a whole high-low period starting
// mid-cycle. Assumes the TAP updates its state after the rising edge.
// Synchronous active-low reset on the falling edge.
module bsc_phase_reg
    import bsc_pkg::*;
#(
    parameter int unsigned INS_W = 3,
    parameter logic [INS_W-1:0] BND_MASK = '1,
    parameter logic [INS_W-1:0] LATCH_MASK = '1
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             st_capture,
    input  logic             st_shift,
    input  logic             st_update,
    input  logic [INS_W-1:0] ins_sel,
    output bsc_phase_t       ph
);

    logic bnd_any;
    logic latch_any;

    // Decode whether any boundary or latch-select instruction is present.
    always_comb begin
        bnd_any   = |(ins_sel & BND_MASK);
        latch_any = |(ins_sel & LATCH_MASK);
    end

    // Sample state on the falling edge; clear on reset.
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            ph <= BSC_PHASE_IDLE;
        end else begin
            ph.cap <= st_capture & bnd_any;
            ph.sft <= st_shift & bnd_any;
            ph.upd <= st_update & bnd_any;
            ph.en  <= st_capture | st_shift;
            ph.sel <= latch_any;
        end
    end

endmodule

// File: rtl/bsc_shift_gen.sv
`timescale 1ns/1ps
// Two-phase shift enable generator.
// The slave enable (active low) is closed during TCK high while shifting.
// The master enable opens only inside the slave's closed window, so the
// two never overlap. At rest both sit low.
module bsc_shift_gen (
    input  logic tck,
    input  logic trst_n,
    input  logic sft,
    output logic shf_a,
    output logic shf_b
);

    logic slave_closed;
    logic master_win;

    // Slave closed (pin high) during high phase of a shift cycle.
    always_comb slave_closed = trst_n & sft & tck;

    // Master window, guarded by the slave being closed.
    always_comb master_win = sft & tck & slave_closed;

    // Drive pins.
    always_comb begin
        shf_b = slave_closed;
        shf_a = master_win;
    end

endmodule

// File: rtl/bsc_strobe_gen.sv
`timescale 1ns/1ps
// Capture, update, select and mode strobes.
// Capture clock dips low during the low phase after a capture sample and
// rises with TCK. Update opens only in the low phase after an update sample.
// All outputs take idle levels while reset is low.
module bsc_strobe_gen
    import bsc_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  bsc_phase_t ph,
    output logic       cap_clk,
    output logic       upd_en,
    output logic       sel_ff,
    output logic       mode_n
);

    logic low_ph;

    // Low phase of TCK, qualified by reset.
    always_comb low_ph = trst_n & ~tck;

    // Capture clock: rest high, pulse low in the capture low phase.
    always_comb cap_clk = ~(low_ph & ph.cap);

    // Update enable: open in the update low phase only.
    always_comb upd_en = low_ph & ph.upd;

    // Latch select and shift mode follow the sampled state.
    always_comb begin
        sel_ff = trst_n & ph.sel;
        mode_n = ~(trst_n & ph.sft);
    end

endmodule

// File: rtl/bsc_gclk.sv
`timescale 1ns/1ps
// Gated capture/shift clock.
// The enable is sampled on the falling edge, so ANDing it with TCK gives
// whole high pulses only.
module bsc_gclk (
    input  logic tck,
    input  logic trst_n,
    input  logic en,
    output logic gclk
);

    // Gate TCK with the falling-edge enable.
    always_comb gclk = trst_n & en & tck;

endmodule

// File: rtl/bscan_clkgen.sv
`timescale 1ns/1ps
// Boundary scan cell clock generator, top level.
// Turns TAP state and instruction selects into latch-cell strobes.
// ins_sel bit 0 external test, bit 1 sample, bit 2 internal test.
module bscan_clkgen
    import bsc_pkg::*;
#(
    parameter int unsigned INS_W = 3,
    parameter logic [INS_W-1:0] BND_MASK = 3'b111,
    parameter logic [INS_W-1:0] LATCH_MASK = 3'b101
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             st_capture,
    input  logic             st_shift,
    input  logic             st_update,
    input  logic [INS_W-1:0] ins_sel,
    output logic             shf_a,
    output logic             shf_b,
    output logic             cap_clk,
    output logic             upd_en,
    output logic             sel_ff,
    output logic             mode_n,
    output logic             gclk
);

    bsc_phase_t ph;

    bsc_phase_reg #(
        .INS_W(INS_W),
        .BND_MASK(BND_MASK),
        .LATCH_MASK(LATCH_MASK)
    ) u_phase (
        .tck(tck),
        .trst_n(trst_n),
        .st_capture(st_capture),
        .st_shift(st_shift),
        .st_update(st_update),
        .ins_sel(ins_sel),
        .ph(ph)
    );

    bsc_shift_gen u_shift (
        .tck(tck),
        .trst_n(trst_n),
        .sft(ph.sft),
        .shf_a(shf_a),
        .shf_b(shf_b)
    );

    bsc_strobe_gen u_strobe (
        .tck(tck),
        .trst_n(trst_n),
        .ph(ph),
        .cap_clk(cap_clk),
        .upd_en(upd_en),
        .sel_ff(sel_ff),
        .mode_n(mode_n)
    );

    bsc_gclk u_gclk (
        .tck(tck),
        .trst_n(trst_n),
        .en(ph.en),
        .gclk(gclk)
    );

endmodule

// File: rtl/bsc_checker.sv
`timescale 1ns/1ps
// Protocol checker for the boundary scan clock generator.
// Sampling on the rising edge sees the low phase; on the falling edge it
// sees the high phase.
module bsc_checker (
    input logic tck,
    input logic trst_n,
    input logic shf_a,
    input logic shf_b,
    input logic cap_clk,
    input logic upd_en,
    input logic sel_ff,
    input logic mode_n,
    input logic gclk
);

    AST_NO_OVERLAP_HI: assert property (@(negedge tck) disable iff (!trst_n) !(shf_a && !shf_b)); // R1
    AST_NO_OVERLAP_LO: assert property (@(posedge tck) disable iff (!trst_n) !(shf_a && !shf_b)); // R1
    AST_SHIFT_LOW_PHASE_IDLE: assert property (@(posedge tck) disable iff (!trst_n) !shf_a && !shf_b); // R2
    AST_CAP_HIGH_IN_HIGH_PHASE: assert property (@(negedge tck) disable iff (!trst_n) cap_clk); // R4
    AST_UPD_SHUT_IN_HIGH_PHASE: assert property (@(negedge tck) disable iff (!trst_n) !upd_en); // R5
    AST_GCLK_LOW_PHASE: assert property (@(posedge tck) disable iff (!trst_n) !gclk); // R8
    AST_MODE_MATCHES_SHIFT: assert property (@(negedge tck) disable iff (!trst_n) shf_a |-> !mode_n); // R7
    AST_RESET_IDLE: assert property (@(posedge tck) !trst_n |-> (!shf_a && !shf_b && cap_clk && !upd_en && !sel_ff && mode_n && !gclk)); // R9

endmodule

bind bscan_clkgen bsc_checker u_chk (
    .tck(tck),
    .trst_n(trst_n),
    .shf_a(shf_a),
    .shf_b(shf_b),
    .cap_clk(cap_clk),
    .upd_en(upd_en),
    .sel_ff(sel_ff),
    .mode_n(mode_n),
    .gclk(gclk)
);

// File: tb/tb_bscan_clkgen.sv
`timescale 1ns/100ps
module tb_bscan_clkgen;

    logic       tck = 1'b0;
    logic       trst_n = 1'b0;
    logic       st_capture = 1'b0;
    logic       st_shift = 1'b0;
    logic       st_update = 1'b0;
    logic [2:0] ins_sel = 3'b000;
    logic shf_a, shf_b, cap_clk, upd_en, sel_ff, mode_n, gclk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference state: what the bench saw at the last falling edge.
    bit m_cap, m_sft, m_upd, m_en, m_sel;

    bscan_clkgen dut (
        .tck(tck), .trst_n(trst_n), .st_capture(st_capture),
        .st_shift(st_shift), .st_update(st_update), .ins_sel(ins_sel),
        .shf_a(shf_a), .shf_b(shf_b), .cap_clk(cap_clk), .upd_en(upd_en),
        .sel_ff(sel_ff), .mode_n(mode_n), .gclk(gclk)
    );

    always #2 tck = ~tck;

    task automatic chk1(input string tag, input string nm, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %b exp %b at %0t", tag, nm, got, exp, $time);
        end
    endtask

    // Compare all outputs against the reference for the given phase.
    task automatic check_all(input bit hi, input string tag);
        bit rst;
        rst = (trst_n == 1'b0);
        chk1({tag, " R1"}, "overlap", shf_a & ~shf_b, 1'b0);
        chk1({tag, " R2 R3"}, "shf_a", shf_a, !rst && hi && m_sft);
        chk1({tag, " R2 R3"}, "shf_b", shf_b, !rst && hi && m_sft);
        chk1({tag, " R4"}, "cap_clk", cap_clk, !(!rst && !hi && m_cap));
        chk1({tag, " R5"}, "upd_en", upd_en, !rst && !hi && m_upd);
        chk1({tag, " R6"}, "sel_ff", sel_ff, !rst && m_sel);
        chk1({tag, " R7"}, "mode_n", mode_n, !(!rst && m_sft));
        chk1({tag, " R8"}, "gclk", gclk, !rst && hi && m_en);
    endtask

    // Apply inputs, model the falling edge, check the low and high phases.
    task automatic step(input bit c, input bit s, input bit u, input logic [2:0] ins, input string tag);
        bit bnd;
        st_capture = c; st_shift = s; st_update = u; ins_sel = ins;
        @(negedge tck);
        bnd = (ins != 3'b000);
        if (trst_n == 1'b0) begin
            m_cap = 0; m_sft = 0; m_upd = 0; m_en = 0; m_sel = 0;
        end else begin
            m_cap = c && bnd; m_sft = s && bnd; m_upd = u && bnd;
            m_en = c || s; m_sel = ins[0] || ins[2];
        end
        #1 check_all(1'b0, tag);
        @(posedge tck);
        #1 check_all(1'b1, tag);
    endtask

    task automatic scan_pass(input logic [2:0] ins, input string tag);
        step(1, 0, 0, ins, tag);
        for (int i = 0; i < 4; i++) step(0, 1, 0, ins, tag);
        step(0, 0, 1, ins, tag);
        step(0, 0, 0, ins, tag);
    endtask

    initial begin
        // R9 reset with shift requested
        st_shift = 1; ins_sel = 3'b001;
        @(posedge tck);
        #1 check_all(1'b1, "R9 reset");
        for (int i = 0; i < 3; i++) step(0, 1, 0, 3'b001, "R9 reset");
        trst_n = 1'b1;
        #0.5 check_all(1'b1, "R9 release");
        #0.4;
        scan_pass(3'b001, "R3 extest");
        scan_pass(3'b010, "R6 sample");
        scan_pass(3'b100, "R6 intest");
        scan_pass(3'b011, "R6 mixed");
        scan_pass(3'b000, "R10 none");
        step(1, 1, 0, 3'b010, "R8 capshift");
        // R9 reset asserted in mid shift high phase
        step(0, 1, 0, 3'b001, "R9 pre");
        step(0, 1, 0, 3'b001, "R9 pre");
        trst_n = 1'b0;
        #0.2 check_all(1'b1, "R9 async");
        step(0, 1, 0, 3'b001, "R9 held");
        step(0, 1, 0, 3'b001, "R9 held");
        trst_n = 1'b1;
        #0.2 check_all(1'b1, "R9 after");
        step(0, 1, 0, 3'b101, "R3 resume");
        step(0, 0, 1, 3'b101, "R5 resume");
        step(0, 0, 0, 3'b000, "R6 clear");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 got hang exp finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule